// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-side protocol engine of a byte-addressed serial memory with 8K locations. It samples the two-wire clock and data lines on the system clock and finds START and STOP conditions. It checks the device address byte, takes in a two-byte word address and acknowledges each accepted byte by pulling the data line low. The data line is driven only through an open-drain enable.

Reads are served from a synchronous memory read port. The engine fetches each byte ahead of its first bit, so the read port can take one cycle of latency. Received write bytes go out one at a time on a strobe interface to a separate page-buffer block. That block is told on STOP that the write command is complete. While a busy input is high, the engine acknowledges nothing, which lets a master poll for the end of an internal write.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset, sdaOe, wrStrobe, wrCommit and memRdEn are low, and the word pointer is 0, so the first current-address read returns location 0.
- R2: A falling data edge while the clock is high is a START, and it aborts any transfer in progress and restarts control-byte reception. A rising data edge while the clock is high is a STOP, which releases the data line and leaves the engine idle. An aborted address leaves the pointer unchanged.
- R3: In the control byte, bits [7:4] must be 1010 and bits [3:1] must equal selPins. Bit 0 selects read (1) or write (0). On a match the engine pulls the data line low for the ninth clock pulse. On a mismatch it gives no acknowledge and ignores every byte until the next START.
- R4: sdaOe changes only while the sampled clock is low. The data line is never driven high.
- R5: While busy is high, no byte is acknowledged, including a matching control byte.
- R6: A write-mode control byte is followed by an address high byte and then an address low byte, each MSB first. The low 5 bits of the high byte and the low byte form the 13-bit pointer, and bits [7:5] of the high byte are ignored. Each later byte is acknowledged and appears for one cycle on wrStrobe, with wrAddr set to the pointer and wrData set to the byte.
- R7: After each written byte, only the low PAGE_W (5) pointer bits increment, so writes wrap within a 32-byte page.
- R8: wrCommit pulses for one cycle on a STOP that ends a write command that carried at least one data byte. A repeated START or a STOP after an address alone gives no pulse.
- R9: A read-mode control byte with no preceding address returns the byte at the pointer, which holds the last accessed location plus one. Read data is taken from memRdData one clock after memRdEn is asserted with memAddr.
- R10: A write-mode control byte with two address bytes, followed by a repeated START and a read-mode control byte, returns the byte at the address just sent.
- R11: A master ACK after a read byte makes the engine send the next location. A master NACK makes it release the data line.
- R12: The pointer increments after each byte read and wraps from 1FFF to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | Pull data line low when high |
| selPins | input | 3 | Strapped device select bits |
| busy | input | 1 | Internal write in progress, suppresses acknowledge |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 13 | Memory read address |
| memRdData | input | 8 | Read data, valid one clock after memRdEn |
| wrStrobe | output | 1 | One-cycle strobe per received write byte |
| wrAddr | output | 13 | Address of the strobed write byte |
| wrData | output | 8 | Strobed write byte |
| wrCommit | output | 1 | Write command ended by STOP |

## Verification
The bench sweeps every select value and every device code. Any wrong decode shows up as an acknowledge on the wrong byte, or as a later byte being acknowledged after a mismatch. A write that starts near the end of a page must wrap into the same page; a design that carries into the upper pointer bits would strobe the wrong address. A sequential read across 1FFF checks that the pointer rolls to 0000, and a repeated START after an address alone checks that no commit is reported. An abort in mid-byte and a poll while busy check that the pointer survives an interrupted transfer and that no acknowledge leaks out while an internal write is running.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} engState_t;
  typedef enum logic [1:0] {K_CTRL, K_AHI, K_ALO, K_DATA} byteKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic latchHi;
    logic loadPtr;
    logic incRead;
    logic wrByte;
    logic fetch;
    logic commit;
    logic driveAck;
    logic driveTx;
  } dpCtl_t;
endpackage

// File: rtl/sms_bus_sampler.sv
module sms_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       busy,
  input  logic [2:0] selPins,
  input  logic [7:0] rxByte,
  output dpCtl_t     ctl
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  engState_t state;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic rdMode;
  logic masterAck;
  logic wrote;
  logic devMatch;
  logic byteEnd;

  assign devMatch = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == selPins);
  assign byteEnd  = sclFall && (bitCnt == BITS_PER_BYTE);

  always_comb begin
    ctl = '0;
    ctl.driveAck = (state == ST_ACK);
    ctl.driveTx  = (state == ST_TX);
    ctl.commit   = stopDet & wrote;
    if (!startDet && !stopDet) begin
      case (state)
        ST_RX: begin
          ctl.shiftIn = sclRise && (bitCnt < BITS_PER_BYTE);
          if (byteEnd && !busy) begin
            case (kind)
              K_CTRL: ctl.fetch   = devMatch & rxByte[0];
              K_AHI:  ctl.latchHi = 1'b1;
              K_ALO:  ctl.loadPtr = 1'b1;
              K_DATA: ctl.wrByte  = 1'b1;
              default: ;
            endcase
          end
        end
        ST_ACK:  ctl.loadTx = sclFall && (kind == K_CTRL) && rdMode;
        ST_TX: begin
          ctl.incRead  = byteEnd;
          ctl.shiftOut = sclFall && !byteEnd;
        end
        ST_MACK: ctl.loadTx = sclFall && masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_CTRL;
      bitCnt    <= '0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
      wrote     <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      kind   <= K_CTRL;
      bitCnt <= '0;
      wrote  <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      wrote <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && (bitCnt < BITS_PER_BYTE)) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) begin
            if (busy) begin
              state <= ST_IDLE;
            end else if (kind == K_CTRL) begin
              if (devMatch) begin
                state  <= ST_ACK;
                rdMode <= rxByte[0];
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_ACK;
              if (kind == K_DATA) wrote <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if ((kind == K_CTRL) && rdMode) begin
              state <= ST_TX;
            end else begin
              state <= ST_RX;
              case (kind)
                K_CTRL:  kind <= K_AHI;
                K_AHI:   kind <= K_ALO;
                default: kind <= K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) state <= ST_MACK;
        end
        ST_MACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sms_datapath.sv
module sms_datapath
  import sms_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  dpCtl_t            ctl,
  input  logic [7:0]        memRdData,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);
  localparam int HI_BITS = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] PTR_ONE = 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  logic [7:0]         rxShift;
  logic [7:0]         txShift;
  logic [7:0]         rdBuf;
  logic [HI_BITS-1:0] hiBits;
  logic [ADDR_W-1:0]  ptr;
  logic               fetchPend;
  logic               rdValid;

  assign rxByte  = rxShift;
  assign memRdEn = ctl.fetch | fetchPend;
  assign memAddr = ptr;
  assign sdaOe   = ctl.driveAck | (ctl.driveTx & ~txShift[7]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      rdBuf     <= '0;
      hiBits    <= '0;
      ptr       <= '0;
      fetchPend <= 1'b0;
      rdValid   <= 1'b0;
      wrStrobe  <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      wrCommit  <= 1'b0;
    end else begin
      fetchPend <= ctl.incRead;
      rdValid   <= memRdEn;
      wrStrobe  <= ctl.wrByte;
      wrCommit  <= ctl.commit;
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (ctl.latchHi) hiBits <= rxShift[HI_BITS-1:0];
      if (rdValid) rdBuf <= memRdData;
      if (ctl.loadTx) txShift <= rdBuf;
      else if (ctl.shiftOut) txShift <= {txShift[6:0], 1'b1};
      if (ctl.loadPtr) begin
        ptr <= {hiBits, rxShift};
      end else if (ctl.incRead) begin
        ptr <= ptr + PTR_ONE;
      end else if (ctl.wrByte) begin
        wrAddr <= ptr;
        wrData <= rxShift;
        ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_ONE};
      end
    end
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sms_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter int         PAGE_W      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        selPins,
  input  logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic ackOn;
  dpCtl_t dpCtl;

  assign ackOn = dpCtl.driveAck;

  sms_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  sms_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .busy(busy), .selPins(selPins),
    .rxByte(rxByte), .ctl(dpCtl)
  );

  sms_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .ctl(dpCtl), .memRdData(memRdData),
    .rxByte(rxByte), .sdaOe(sdaOe), .memRdEn(memRdEn), .memAddr(memAddr),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit)
  );
endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic clk,
  input logic rstN,
  input logic sclS,
  input logic startDet,
  input logic stopDet,
  input logic sdaOe,
  input logic busy,
  input logic ackOn,
  input logic wrStrobe,
  input logic wrCommit
);
  // R4
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  // R5
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOn) |-> !$past(busy));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaOe);

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R8
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(stopDet));
endmodule

bind serial_mem_slave sms_checker u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startDet(startDet), .stopDet(stopDet),
  .sdaOe(sdaOe), .busy(busy), .ackOn(ackOn), .wrStrobe(wrStrobe), .wrCommit(wrCommit)
);

// File: tb/serial_mem_slave_bench.sv
`timescale 1ns/1ps
module serial_mem_slave_bench;
  localparam int H = 10;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] CR = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic busy = 1'b0;
  logic sdaBus;
  logic sdaOe, memRdEn, wrStrobe, wrCommit;
  logic [12:0] memAddr, wrAddr;
  logic [7:0] memRdData, wrData;

  int checks = 0;
  int fails = 0;
  int logCnt = 0;
  int commitCnt = 0;
  int r4Viol = 0;
  bit done = 0;
  logic [12:0] logAddr [0:15];
  logic [7:0]  logData [0:15];
  logic sclPrevB = 1'b1;
  logic oePrev = 1'b0;

  always #10 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  serial_mem_slave u_serial_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .selPins(SEL), .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .wrCommit(wrCommit)
  );

  function automatic logic [7:0] patt(input logic [12:0] a);
    return a[7:0] ^ {3'b101, a[12:8]};
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= patt(memAddr);
    if (rstN && wrStrobe && logCnt < 16) begin
      logAddr[logCnt] <= wrAddr;
      logData[logCnt] <= wrData;
      logCnt <= logCnt + 1;
    end
    if (rstN && wrCommit) commitCnt <= commitCnt + 1;
  end

  // R4 monitor: data drive must not move while the bus clock stays high
  always @(negedge clk) begin
    if (rstN && sclPrevB && scl && (sdaOe !== oePrev)) r4Viol = r4Viol + 1;
    sclPrevB = scl;
    oePrev = sdaOe;
  end

  task automatic waitC(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitC(H);
    scl = 1'b1; waitC(H);
    sdaM = 1'b0; waitC(H);
    scl = 1'b0; waitC(H);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitC(H);
    scl = 1'b1; waitC(H);
    sdaM = 1'b1; waitC(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitC(H);
      scl = 1'b1; waitC(H);
      scl = 1'b0; waitC(2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitC(H);
    scl = 1'b1; waitC(H/2);
    acked = (sdaBus == 1'b0);
    waitC(H/2);
    scl = 1'b0; waitC(2);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitC(H);
      scl = 1'b1; waitC(H/2);
      b[i] = sdaBus;
      waitC(H/2);
      scl = 1'b0;
    end
    waitC(2);
    sdaM = ackIt ? 1'b0 : 1'b1; waitC(H);
    scl = 1'b1; waitC(H);
    scl = 1'b0; waitC(2);
    sdaM = 1'b1;
  endtask

  task automatic curRead(input string tag, input logic [12:0] a);
    logic ak;
    logic [7:0] d;
    busStart();
    sendByte(CR, ak);
    checkEq({tag, " ack"}, int'(ak), 1);
    recvByte(1'b0, d);
    checkEq({tag, " data"}, int'(d), int'(patt(a)));
    busStop();
  endtask

  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    logic ak;
    busStart();
    sendByte(CW, ak); checkEq({tag, " ctrl ack"}, int'(ak), 1);
    sendByte(hi, ak); checkEq({tag, " hi ack"}, int'(ak), 1);
    sendByte(lo, ak); checkEq({tag, " lo ack"}, int'(ak), 1);
  endtask

  initial begin
    logic ak;
    logic [7:0] d;
    waitC(5);
    rstN = 1'b1;
    waitC(2);
    // R1 reset state
    checkEq("R1 sdaOe", int'(sdaOe), 0);
    checkEq("R1 wrStrobe", int'(wrStrobe), 0);
    checkEq("R1 wrCommit", int'(wrCommit), 0);
    checkEq("R1 memRdEn", int'(memRdEn), 0);

    // R1 / R9 current-address reads start at 0 and advance
    curRead("R1 R9 first read", 13'h0000);
    curRead("R9 second read", 13'h0001);

    // R3 select sweep
    for (int s = 0; s < 8; s++) begin
      busStart();
      sendByte({4'b1010, 3'(s), 1'b0}, ak);
      checkEq($sformatf("R3 select %0d", s), int'(ak), int'(s == 5));
      if (s != 5) begin
        sendByte(8'h00, ak);
        checkEq($sformatf("R3 ignore after select %0d", s), int'(ak), 0);
      end
      busStop();
    end
    // R3 device code sweep
    for (int c = 0; c < 16; c++) begin
      if (c != 10) begin
        busStart();
        sendByte({4'(c), SEL, 1'b1}, ak);
        checkEq($sformatf("R3 code %0h", c), int'(ak), 0);
        busStop();
      end
    end
    curRead("R3 pointer kept", 13'h0002);

    // R6 R7 R8 page write near page end, top address bits set
    setAddr(8'hE3, 8'h1E, "R6");
    sendByte(8'h11, ak); checkEq("R6 data0 ack", int'(ak), 1);
    sendByte(8'h22, ak); checkEq("R6 data1 ack", int'(ak), 1);
    sendByte(8'h33, ak); checkEq("R6 data2 ack", int'(ak), 1);
    busStop();
    waitC(5);
    checkEq("R6 strobe count", logCnt, 3);
    checkEq("R6 addr0", int'(logAddr[0]), 'h031E);
    checkEq("R7 addr1", int'(logAddr[1]), 'h031F);
    checkEq("R7 addr2 page wrap", int'(logAddr[2]), 'h0300);
    checkEq("R6 data0", int'(logData[0]), 'h11);
    checkEq("R6 data2", int'(logData[2]), 'h33);
    checkEq("R8 commit on stop", commitCnt, 1);
    curRead("R7 pointer after write", 13'h0301);

    // R10 R11 random then sequential read, R8 no commit on repeated start
    setAddr(8'h0A, 8'hBC, "R10");
    busStart();
    sendByte(CR, ak); checkEq("R10 read ctrl ack", int'(ak), 1);
    for (int k = 0; k < 4; k++) begin
      recvByte(k != 3, d);
      checkEq($sformatf("R11 seq byte %0d", k), int'(d), int'(patt(13'h0ABC + 13'(k))));
    end
    waitC(4);
    checkEq("R11 released after nack", int'(sdaOe), 0);
    busStop();
    waitC(5);
    checkEq("R8 no commit on repeated start", commitCnt, 1);
    checkEq("R8 no stray strobes", logCnt, 3);

    // R12 wrap across top of memory
    setAddr(8'h1F, 8'hFE, "R12");
    busStart();
    sendByte(CR, ak); checkEq("R12 read ctrl ack", int'(ak), 1);
    for (int k = 0; k < 4; k++) begin
      recvByte(k != 3, d);
      checkEq($sformatf("R12 wrap byte %0d", k), int'(d), int'(patt(13'h1FFE + 13'(k))));
    end
    busStop();

    // R2 START in mid-byte aborts the address
    busStart();
    sendByte(CW, ak); checkEq("R2 ctrl ack", int'(ak), 1);
    sendBits(8'h55, 4);
    busStart();
    sendByte(CR, ak); checkEq("R2 restart ack", int'(ak), 1);
    recvByte(1'b0, d);
    checkEq("R2 pointer kept after abort", int'(d), int'(patt(13'h0002)));
    busStop();
    // R2 STOP after high address byte only
    busStart();
    sendByte(CW, ak);
    sendByte(8'h07, ak);
    busStop();
    curRead("R2 pointer kept after stop", 13'h0003);
    checkEq("R8 no commit without data", commitCnt, 1);

    // R5 busy suppresses every acknowledge
    busy = 1'b1;
    busStart();
    sendByte(CW, ak); checkEq("R5 busy write ctrl", int'(ak), 0);
    busStop();
    busStart();
    sendByte(CR, ak); checkEq("R5 busy read ctrl", int'(ak), 0);
    busStop();
    busy = 1'b0;
    curRead("R5 after busy", 13'h0004);

    checkEq("R4 drive changes under high clock", r4Viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule